// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer that joins two unrelated clock domains. Words enter on the write clock and leave on the read clock, and the two clocks may run at any frequency relative to each other. Each pointer crosses to the other domain as Gray code through a chain of synchronizing flops. The status flags are computed in each domain from its own pointer and the synchronized copy of the other pointer.

The output timing is chosen once, while master reset is held. In standard mode the output register changes only when the reader asks for a word, and the two flag outputs mean "storage empty" and "storage full". In fall-through mode the oldest word is moved onto the output by itself. The reader then takes it by pulling the read enable low, and the two flag outputs mean "output holds a valid word" and "room for another write". A half-full indication is produced in both modes.

Master reset is a synchronous, active-high input that both domains sample. It must be held for at least two rising edges of each clock.

Top module: `dual_mode_fifo`

## Requirements
- R1: `fwft_sel` is captured while `mrst` is high (0 = standard, 1 = fall-through). Changes to `fwft_sel` after `mrst` falls have no effect until the next master reset.
- R2: After master reset, `rd_data` is 0 and `half_full` is 0. In standard mode `out_flag` = 1 and `in_flag` = 0. In fall-through mode `out_flag` = 0 and `in_flag` = 1.
- R3: A word is stored on a rising `wr_clk` edge when `wr_en_n` is 0 and storage is not full. A write attempted while storage is full is discarded and never read back.
- R4: In standard mode `rd_data` changes only on a rising `rd_clk` edge where `rd_en_n` is 0 and storage is not empty. That edge loads the oldest stored word.
- R5: In fall-through mode, a word written into an empty FIFO appears on `rd_data`, with `out_flag` = 1, on the third rising `rd_clk` edge after the write edge, while `rd_en_n` stays 1.
- R6: In fall-through mode, while `out_flag` = 1 and `rd_en_n` = 1, `rd_data` and `out_flag` hold. A rising `rd_clk` edge with `rd_en_n` = 0 replaces the word with the next stored one, or clears `out_flag` if none is stored.
- R7: A read request while storage is empty is ignored, in either mode. The read pointer does not move, and the next word written is the next word delivered.
- R8: `in_flag` reports storage full. In standard mode it is 1 when DEPTH words are stored. In fall-through mode it is 0 when DEPTH words are stored, not counting the word presented on `rd_data`, so DEPTH+1 words can be held in total.
- R9: `half_full` is 1 when the write domain's count of stored words exceeds DEPTH/2, in both modes.
- R10: Words leave in the order they were written, with the two clocks unrelated.
- R11: In standard mode `out_flag` falls on the second rising `rd_clk` edge after a write into empty storage. It rises again on the read edge that removes the last stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst | input | 1 | Master reset, synchronous, active high, sampled by both clocks |
| fwft_sel | input | 1 | Timing mode captured during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Word to be written |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DATA_W | Registered output word |
| out_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| in_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words in storage |

## Verification
The write pointer needs one write edge plus two read edges to reach the read domain. The standard empty flag therefore falls on the second read edge after a write, and the fall-through word lands on the third. The bench records the write edge and counts read edges from it, sampling 1.5 ns after each edge. The two clocks have 10 ns and 14 ns periods, with all write edges at odd and all read edges at even nanoseconds, so no edge of one clock coincides with the other. Full and half-full react on the write edge that stores the word, and reads update `rd_data` and the standard empty flag on the read edge itself. These results are sampled just after that edge, and the bench waits several cycles wherever a value must first cross a domain.

// File: rtl/fifo_mode_pkg.sv
package fifo_mode_pkg;
  // Output timing selected during master reset.
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stage[s-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/fifo_dp_ram.sv
module fifo_dp_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; this register is also the block's output word.
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import fifo_mode_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sel,
  input  logic          wr_en_n,
  input  logic [AW:0]   rgray_sync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wptr,
  output logic          full,
  output rd_mode_e      mode,
  output logic          in_flag,
  output logic          half_full
);
  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] HALF  = (AW+1)'(DEPTH / 2);

  logic [AW:0] rbin_sync;
  logic [AW:0] wnext;
  logic [AW:0] level;

  always_comb begin
    rbin_sync[AW] = rgray_sync[AW];
    for (int i = AW - 1; i >= 0; i--) begin
      rbin_sync[i] = rbin_sync[i+1] ^ rgray_sync[i];
    end
  end

  assign full  = (wgray == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
  assign we    = !rst && !wr_en_n && !full;
  assign wnext = wptr + 1'b1;
  assign waddr = wptr[AW-1:0];
  assign level = wptr - rbin_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= rd_mode_e'(mode_sel);
      wptr  <= '0;
      wgray <= '0;
    end else if (we) begin
      wptr  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end
  end

  assign in_flag   = (mode == MODE_FWFT) ? !full : full;
  assign half_full = (level > HALF);
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
  import fifo_mode_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sel,
  input  logic          rd_en_n,
  input  logic [AW:0]   wgray_sync,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rptr,
  output logic          empty,
  output logic          held,
  output rd_mode_e      mode,
  output logic          out_flag
);
  logic [AW:0] rnext;
  logic        want;

  assign empty = (rgray == wgray_sync);

  // Standard: load only on request. Fall-through: refill whenever the
  // output register is free or being taken.
  always_comb begin
    if (mode == MODE_FWFT) want = !held || !rd_en_n;
    else                   want = !rd_en_n;
  end

  assign re    = !rst && want && !empty;
  assign rnext = rptr + 1'b1;
  assign raddr = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= rd_mode_e'(mode_sel);
      rptr  <= '0;
      rgray <= '0;
      held  <= 1'b0;
    end else if (re) begin
      rptr  <= rnext;
      rgray <= rnext ^ (rnext >> 1);
      held  <= (mode == MODE_FWFT);
    end else if (mode == MODE_FWFT && !rd_en_n) begin
      held  <= 1'b0;
    end
  end

  assign out_flag = (mode == MODE_FWFT) ? held : empty;
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import fifo_mode_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst,
  input  logic              fwft_sel,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_flag,
  output logic              in_flag,
  output logic              half_full
);
  logic              w_we, r_re;
  logic [ADDR_W-1:0] w_addr, r_addr;
  logic [ADDR_W:0]   w_gray, r_gray, w_gray_s, r_gray_s;
  logic [ADDR_W:0]   w_ptr, r_ptr;
  logic              w_full, r_empty, r_held;
  rd_mode_e          w_mode, r_mode;

  fifo_wr_side #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(mrst), .mode_sel(fwft_sel), .wr_en_n(wr_en_n),
    .rgray_sync(r_gray_s), .we(w_we), .waddr(w_addr), .wgray(w_gray),
    .wptr(w_ptr), .full(w_full), .mode(w_mode), .in_flag(in_flag),
    .half_full(half_full)
  );

  fifo_rd_side #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(mrst), .mode_sel(fwft_sel), .rd_en_n(rd_en_n),
    .wgray_sync(w_gray_s), .re(r_re), .raddr(r_addr), .rgray(r_gray),
    .rptr(r_ptr), .empty(r_empty), .held(r_held), .mode(r_mode),
    .out_flag(out_flag)
  );

  fifo_gray_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(mrst), .d(w_gray), .q(w_gray_s)
  );

  fifo_gray_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(mrst), .d(r_gray), .q(r_gray_s)
  );

  fifo_dp_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(w_we), .waddr(w_addr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(mrst), .re(r_re), .raddr(r_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/fifo_flow_checker.sv
module fifo_flow_checker
  import fifo_mode_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic [AW:0]   w_ptr,
  input logic [AW:0]   w_gray,
  input logic [AW:0]   r_ptr,
  input logic          w_full,
  input logic          r_empty,
  input rd_mode_e      r_mode,
  input logic [DW-1:0] rd_data,
  input logic          out_flag
);
  logic rst_seen_r;
  always_ff @(posedge rd_clk) rst_seen_r <= mrst;

  // R2: one read edge after reset, the read side sits at the start
  always @(posedge rd_clk) begin
    if (rst_seen_r) begin
      p_reset_state_r2: assert (r_ptr == '0 && rd_data == '0);
    end
  end

  p_mode_fixed_r1: assert property (@(posedge rd_clk) disable iff (mrst)
    !mrst |=> $stable(r_mode));

  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (mrst)
    (w_full && !wr_en_n) |=> $stable(w_ptr));

  p_std_hold_r4: assert property (@(posedge rd_clk) disable iff (mrst)
    (r_mode == MODE_STD && rd_en_n) |=> $stable(rd_data));

  p_fwft_hold_r6: assert property (@(posedge rd_clk) disable iff (mrst)
    (r_mode == MODE_FWFT && out_flag && rd_en_n) |=> (out_flag && $stable(rd_data)));

  p_no_underflow_r7: assert property (@(posedge rd_clk) disable iff (mrst)
    r_empty |=> $stable(r_ptr));

  p_gray_step_r10: assert property (@(posedge wr_clk) disable iff (mrst)
    !mrst |=> ($countones(w_gray ^ $past(w_gray)) <= 1));
endmodule

bind dual_mode_fifo fifo_flow_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n), .w_ptr(w_ptr), .w_gray(w_gray), .r_ptr(r_ptr),
  .w_full(w_full), .r_empty(r_empty), .r_mode(r_mode), .rd_data(rd_data),
  .out_flag(out_flag)
);

// File: tb/tb_dual_mode_fifo.sv
`timescale 1ns/100ps
module tb_dual_mode_fifo;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic mrst = 1'b1, fwft_sel = 1'b0, wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic out_flag, in_flag, half_full;

  int n_checks = 0;
  int n_fail = 0;

  // write edges at odd ns, read edges at even ns: never coincident
  always #5 wr_clk = ~wr_clk;
  initial begin
    #2 rd_clk = 1'b1;
    forever #7 rd_clk = ~rd_clk;
  end

  dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .fwft_sel(fwft_sel),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .out_flag(out_flag), .in_flag(in_flag),
    .half_full(half_full)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr_tick();
    @(posedge wr_clk); #1.5;
  endtask

  task automatic rd_tick();
    @(posedge rd_clk); #1.5;
  endtask

  task automatic do_reset(input logic mode);
    fwft_sel = mode; wr_en_n = 1'b1; rd_en_n = 1'b1; mrst = 1'b1;
    repeat (4) wr_tick();
    mrst = 1'b0;
    wr_tick();
  endtask

  task automatic push(input logic [DW-1:0] d);
    wr_data = d; wr_en_n = 1'b0;
    wr_tick();
    wr_en_n = 1'b1;
  endtask

  task automatic pop();
    rd_en_n = 1'b0;
    rd_tick();
    rd_en_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    chk("R2 std rd_data", 32'(rd_data), 0);
    chk("R2 std out_flag", 32'(out_flag), 1);
    chk("R2 std in_flag", 32'(in_flag), 0);
    chk("R2 std half_full", 32'(half_full), 0);
    do_reset(1'b1);
    chk("R2 fwft out_flag", 32'(out_flag), 0);
    chk("R2 fwft in_flag", 32'(in_flag), 1);
  endtask

  task automatic t_std_latency();
    do_reset(1'b0);
    @(negedge wr_clk);
    wr_data = 16'hA1B2; wr_en_n = 1'b0;
    @(posedge wr_clk);
    fork
      begin #1.5 wr_en_n = 1'b1; end
      begin
        rd_tick(); chk("R11 empty after 1st read edge", 32'(out_flag), 1);
        rd_tick(); chk("R11 empty clears on 2nd read edge", 32'(out_flag), 0);
        chk("R4 no data before read", 32'(rd_data), 0);
      end
    join
    repeat (3) rd_tick();
    chk("R4 still no data without read", 32'(rd_data), 0);
    pop();
    chk("R4 read delivers word", 32'(rd_data), 32'h0000A1B2);
    chk("R11 empty after last word read", 32'(out_flag), 1);
  endtask

  task automatic t_std_underflow();
    do_reset(1'b0);
    rd_en_n = 1'b0;
    repeat (3) rd_tick();
    rd_en_n = 1'b1;
    chk("R7 read on empty leaves data", 32'(rd_data), 0);
    chk("R7 still empty", 32'(out_flag), 1);
    push(16'h5A5A);
    repeat (4) rd_tick();
    pop();
    chk("R7 next written word is read", 32'(rd_data), 32'h00005A5A);
  endtask

  task automatic t_std_full();
    do_reset(1'b0);
    for (int i = 0; i < DEPTH / 2; i++) push(16'(16'h0100 + i));
    chk("R9 half_full at DEPTH/2", 32'(half_full), 0);
    push(16'(16'h0100 + DEPTH / 2));
    chk("R9 half_full above DEPTH/2", 32'(half_full), 1);
    for (int i = DEPTH / 2 + 1; i < DEPTH; i++) push(16'(16'h0100 + i));
    chk("R8 std full at DEPTH", 32'(in_flag), 1);
    push(16'hDEAD);
    chk("R3 full stays set", 32'(in_flag), 1);
    repeat (3) rd_tick();
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      chk("R10 std order", 32'(rd_data), 32'(16'h0100 + i));
    end
    chk("R3 dropped word absent, empty", 32'(out_flag), 1);
    pop();
    chk("R7 extra read keeps last word", 32'(rd_data), 32'(16'h0100 + DEPTH - 1));
    repeat (4) wr_tick();
    chk("R8 full clears after reads", 32'(in_flag), 0);
  endtask

  task automatic t_fwft_latency();
    do_reset(1'b1);
    fwft_sel = 1'b0;
    @(negedge wr_clk);
    wr_data = 16'hC3C3; wr_en_n = 1'b0;
    @(posedge wr_clk);
    fork
      begin #1.5 wr_en_n = 1'b1; end
      begin
        rd_tick(); chk("R5 not ready after edge 1", 32'(out_flag), 0);
        rd_tick(); chk("R5 not ready after edge 2", 32'(out_flag), 0);
        rd_tick(); chk("R5 ready on edge 3", 32'(out_flag), 1);
        chk("R1 R5 word falls through", 32'(rd_data), 32'h0000C3C3);
      end
    join
  endtask

  task automatic t_fwft_advance();
    do_reset(1'b1);
    push(16'h000A); push(16'h000B); push(16'h000C);
    repeat (6) rd_tick();
    chk("R6 head word presented", 32'(rd_data), 32'h000A);
    repeat (3) rd_tick();
    chk("R6 held without read", 32'(rd_data), 32'h000A);
    chk("R6 ready held", 32'(out_flag), 1);
    rd_en_n = 1'b0;
    rd_tick(); chk("R6 advance to B", 32'(rd_data), 32'h000B);
    rd_tick(); chk("R6 advance to C", 32'(rd_data), 32'h000C);
    rd_tick(); chk("R6 ready drops when drained", 32'(out_flag), 0);
    rd_tick(); rd_tick();
    rd_en_n = 1'b1;
    chk("R7 fwft read while not ready", 32'(out_flag), 0);
    push(16'h000D);
    repeat (6) rd_tick();
    chk("R7 fwft next word delivered", 32'(rd_data), 32'h000D);
  endtask

  task automatic t_fwft_full();
    do_reset(1'b1);
    push(16'h0200);
    repeat (6) rd_tick();
    repeat (4) wr_tick();
    for (int i = 1; i <= DEPTH; i++) push(16'(16'h0200 + i));
    chk("R8 fwft input not ready", 32'(in_flag), 0);
    chk("R9 fwft half_full", 32'(half_full), 1);
    push(16'hBEEF);
    repeat (3) rd_tick();
    chk("R10 fwft head", 32'(rd_data), 32'h0200);
    for (int i = 1; i <= DEPTH; i++) begin
      pop();
      chk("R10 fwft order", 32'(rd_data), 32'(16'h0200 + i));
    end
    pop();
    chk("R3 fwft dropped word absent", 32'(out_flag), 0);
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_std_latency();
    t_std_underflow();
    t_std_full();
    t_fwft_latency();
    t_fwft_advance();
    t_fwft_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule